// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block connects two synchronous agents, called port A and port B, that each run on their own free-running clock. Two independent first-in first-out buffers sit between them. One carries words from A to B and the other carries words from B to A. The two clocks may be unrelated in frequency and phase, or they may be the same clock.

Each port has a single shared data bus, modelled as an input word plus an output word with an output-enable. An active-low chip select and a write/read select decide whether the port is writing into its outgoing buffer or reading from its incoming buffer. Separate write and read enables then qualify the transfer on the port's rising clock edge. Transfers are gated by ready flags rather than by full or empty. Input-ready means the outgoing buffer can accept a word. Output-ready means the oldest incoming word is already on the bus, so a read takes that word on the same edge that accepts it.

Each port also sees a half-full flag and a programmable almost-full/almost-empty flag for its outgoing buffer. Both flags are computed in that port's own clock domain. The almost threshold is captured from a configuration input while reset is active. Pointers cross between the clock domains as Gray code through two-flop synchronizers.

Top module: `bdfPair`

## Requirements
- R1: On a rising edge of its clock, a port stores `din` into its outgoing buffer only when `csN`=0, `wrSel`=1, `wen`=1 and `inReady`=1. Any other combination stores nothing.
- R2: Words come out at the opposite port in the order they were written. While `outReady`=1 the bus shows the oldest word. That word is consumed on a rising edge with `csN`=0, `wrSel`=0 and `ren`=1, and it stays on the bus until it is consumed.
- R3: `doutOe` is 1 exactly when `csN`=0 and `wrSel`=0. While `doutOe` is 0, `dout` is all zeros.
- R4: `outReady` is 0 while the incoming buffer holds no word. It becomes 1 a few reader-clock cycles after a word has been written on the far port.
- R5: `inReady` stays 1 while the outgoing buffer holds fewer than DEPTH (512) words. It is 0 right after the write of the DEPTH-th word. A write attempted while it is 0 is dropped.
- R6: `halfFull` is 1 while the outgoing buffer holds at least DEPTH/2+1 (257) words, as counted by the writing port.
- R7: `almost` is 1 while the outgoing-buffer count is at or below the offset, or at or above DEPTH minus the offset.
- R8: The offset is captured from `cfgOff` while the port's reset is active. A captured value of 0 selects the default offset of 8.
- R9: A reset pulse on either port empties both buffers. After it, both `outReady` flags are 0, both `inReady` flags are 1, and the first word read is the first word written after the reset.
- R10: The two directions are independent. Words written at port B reach port A with their order and values intact.
- R11: A read request made while `outReady`=0 has no effect on either buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A free-running clock |
| rstA | input | 1 | Port A synchronous reset, active high |
| cfgOffA | input | 9 | Almost-flag offset for the A-to-B buffer, captured in reset |
| csNA | input | 1 | Port A chip select, active low |
| wrSelA | input | 1 | Port A direction: 1 = write, 0 = read |
| wenA | input | 1 | Port A write enable |
| renA | input | 1 | Port A read enable |
| dinA | input | 18 | Port A write data |
| doutA | output | 18 | Port A read data (zero when not enabled) |
| doutOeA | output | 1 | Port A bus drive enable |
| inReadyA | output | 1 | A-to-B buffer can accept a word |
| outReadyA | output | 1 | A B-to-A word is present on doutA |
| halfFullA | output | 1 | A-to-B buffer at least half full plus one |
| almostA | output | 1 | A-to-B buffer almost empty or almost full |
| clkB | input | 1 | Port B free-running clock |
| rstB | input | 1 | Port B synchronous reset, active high |
| cfgOffB | input | 9 | Almost-flag offset for the B-to-A buffer, captured in reset |
| csNB | input | 1 | Port B chip select, active low |
| wrSelB | input | 1 | Port B direction: 1 = write, 0 = read |
| wenB | input | 1 | Port B write enable |
| renB | input | 1 | Port B read enable |
| dinB | input | 18 | Port B write data |
| doutB | output | 18 | Port B read data (zero when not enabled) |
| doutOeB | output | 1 | Port B bus drive enable |
| inReadyB | output | 1 | B-to-A buffer can accept a word |
| outReadyB | output | 1 | An A-to-B word is present on doutB |
| halfFullB | output | 1 | B-to-A buffer at least half full plus one |
| almostB | output | 1 | B-to-A buffer almost empty or almost full |

## Verification
The hardest state to reach from the ports is a completely full buffer whose pointers have already wrapped. It has to be reached while the threshold flags pass their exact boundary counts. The stimulus first sends a few words through the gating table, then fills the A-to-B buffer with 512 back-to-back writes while the far side stays idle. This keeps the synchronized read pointer still, so every flag edge falls on a known write count. The second hard case is a reset on only one port while both buffers hold words. It is reached by parking words on both output registers and then pulsing a single reset long enough to cross into the other clock domain.

// File: rtl/bdf_pkg.sv
`timescale 1ns/1ps
package bdf_pkg;
  // strobes from pointer control to the storage datapath
  typedef struct packed {
    logic wrStb;  // write din into array (writer clock)
    logic ldStb;  // load output register from array (reader clock)
  } memStb_t;
endpackage

// File: rtl/bdfDatapath.sv
`timescale 1ns/1ps
module bdfDatapath
  import bdf_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  memStb_t           stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  // output register: holds the oldest word until control reloads it
  always_ff @(posedge rdClk) begin
    if (stb.ldStb) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/bdfCtrl.sv
`timescale 1ns/1ps
module bdfCtrl
  import bdf_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          wrClk,
  input  logic          wrRst,
  input  logic          rdClk,
  input  logic          rdRst,
  input  logic [AW-1:0] cfgOff,
  input  logic          wrReq,
  input  logic          rdReq,
  output memStb_t       stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          inReady,
  output logic          outReady,
  output logic          halfFull,
  output logic          almost
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2 + 1);
  localparam logic [AW-1:0] DEF_CNT  = AW'(DEF_OFF);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- writer clock domain ----------------
  logic [PW-1:0] wrBin, wrGray, popSync1, popSync2, popBinW, wrCount;
  logic [AW-1:0] offReg;
  logic          wrGo;

  // ---------------- reader clock domain ----------------
  logic [PW-1:0] fetchBin, popBin, popGray, wrSync1, wrSync2, wrBinR;
  logic          outValid, popGo, ldGo;

  assign popBinW = fromGray(popSync2);
  assign wrCount = wrBin - popBinW;
  assign inReady = !wrRst && (wrCount != FULL_CNT);
  assign wrGo    = wrReq && inReady;
  assign halfFull = (wrCount >= HALF_CNT);
  assign almost   = (wrCount <= {1'b0, offReg}) ||
                    (wrCount >= (FULL_CNT - {1'b0, offReg}));

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wrBin    <= '0;
      wrGray   <= '0;
      popSync1 <= '0;
      popSync2 <= '0;
      offReg   <= (cfgOff == '0) ? DEF_CNT : cfgOff;
    end else begin
      if (wrGo) wrBin <= wrBin + 1'b1;
      wrGray   <= toGray(wrBin);
      popSync1 <= popGray;
      popSync2 <= popSync1;
    end
  end

  assign wrBinR   = fromGray(wrSync2);
  assign popGo    = rdReq && outValid;
  assign ldGo     = (fetchBin != wrBinR) && (!outValid || popGo);
  assign outReady = outValid;

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      fetchBin <= '0;
      popBin   <= '0;
      popGray  <= '0;
      wrSync1  <= '0;
      wrSync2  <= '0;
      outValid <= 1'b0;
    end else begin
      if (ldGo)  fetchBin <= fetchBin + 1'b1;
      if (popGo) popBin   <= popBin + 1'b1;
      outValid <= ldGo || (outValid && !popGo);
      popGray  <= toGray(popBin);
      wrSync1  <= wrGray;
      wrSync2  <= wrSync1;
    end
  end

  assign stb    = '{wrStb: wrGo, ldStb: ldGo};
  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = fetchBin[AW-1:0];

  // R5
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    wrCount <= FULL_CNT);

  // R5
  ir_fall_on_write_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    $fell(inReady) |-> $past(wrGo));

  // R6
  hf_rise_on_write_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    $rose(halfFull) |-> $past(wrGo));

  // R4
  or_backed_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    outValid |-> (wrBinR != popBin));
endmodule

// File: rtl/bdfPair.sv
`timescale 1ns/1ps
module bdfPair
  import bdf_pkg::*;
#(
  parameter int WORD_W  = 18,
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 8,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clkA,
  input  logic              rstA,
  input  logic [AW-1:0]     cfgOffA,
  input  logic              csNA,
  input  logic              wrSelA,
  input  logic              wenA,
  input  logic              renA,
  input  logic [WORD_W-1:0] dinA,
  output logic [WORD_W-1:0] doutA,
  output logic              doutOeA,
  output logic              inReadyA,
  output logic              outReadyA,
  output logic              halfFullA,
  output logic              almostA,
  input  logic              clkB,
  input  logic              rstB,
  input  logic [AW-1:0]     cfgOffB,
  input  logic              csNB,
  input  logic              wrSelB,
  input  logic              wenB,
  input  logic              renB,
  input  logic [WORD_W-1:0] dinB,
  output logic [WORD_W-1:0] doutB,
  output logic              doutOeB,
  output logic              inReadyB,
  output logic              outReadyB,
  output logic              halfFullB,
  output logic              almostB
);
  // index 0 = port A, index 1 = port B; direction g is written at port g
  logic              clkV [2];
  logic              rstV [2];
  logic              rstLoc [2];
  logic [AW-1:0]     cfgV [2];
  logic              csNV [2], wrSelV [2], wenV [2], renV [2];
  logic [WORD_W-1:0] dinV [2], doutV [2], rdDataDir [2];
  logic              oeV [2], wrReqV [2], rdReqV [2];
  logic              irV [2], orDir [2], hfV [2], afV [2];

  assign clkV   = '{clkA, clkB};
  assign rstV   = '{rstA, rstB};
  assign cfgV   = '{cfgOffA, cfgOffB};
  assign csNV   = '{csNA, csNB};
  assign wrSelV = '{wrSelA, wrSelB};
  assign wenV   = '{wenA, wenB};
  assign renV   = '{renA, renB};
  assign dinV   = '{dinA, dinB};

  for (genvar g = 0; g < 2; g++) begin : gPort
    logic [1:0] peerSync;
    always_ff @(posedge clkV[g]) peerSync <= {peerSync[0], rstV[1-g]};
    assign rstLoc[g] = rstV[g] || peerSync[1];

    assign wrReqV[g] = !csNV[g] && wrSelV[g] && wenV[g];
    assign rdReqV[g] = !csNV[g] && !wrSelV[g] && renV[g];
    assign oeV[g]    = !csNV[g] && !wrSelV[g];
    assign doutV[g]  = oeV[g] ? rdDataDir[1-g] : '0;

    memStb_t       stb;
    logic [AW-1:0] wrAddr, rdAddr;

    bdfCtrl #(.DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) ctrl_i (
      .wrClk(clkV[g]), .wrRst(rstLoc[g]), .rdClk(clkV[1-g]), .rdRst(rstLoc[1-g]),
      .cfgOff(cfgV[g]), .wrReq(wrReqV[g]), .rdReq(rdReqV[1-g]), .stb(stb),
      .wrAddr(wrAddr), .rdAddr(rdAddr), .inReady(irV[g]), .outReady(orDir[g]),
      .halfFull(hfV[g]), .almost(afV[g])
    );

    bdfDatapath #(.WORD_W(WORD_W), .DEPTH(DEPTH)) data_i (
      .wrClk(clkV[g]), .rdClk(clkV[1-g]), .stb(stb), .wrAddr(wrAddr),
      .wrData(dinV[g]), .rdAddr(rdAddr), .rdData(rdDataDir[g])
    );

    // R2
    dout_hold_chk: assert property (@(posedge clkV[g]) disable iff (rstLoc[g])
      (orDir[1-g] && !rdReqV[g]) |=> $stable(rdDataDir[1-g]));
  end

  assign doutA     = doutV[0];
  assign doutOeA   = oeV[0];
  assign inReadyA  = irV[0];
  assign outReadyA = orDir[1];
  assign halfFullA = hfV[0];
  assign almostA   = afV[0];
  assign doutB     = doutV[1];
  assign doutOeB   = oeV[1];
  assign inReadyB  = irV[1];
  assign outReadyB = orDir[0];
  assign halfFullB = hfV[1];
  assign almostB   = afV[1];
endmodule

// File: tb/bdfPair_tb.sv
`timescale 1ns/1ps
module bdfPair_tb_top;
  logic clkA = 0, clkB = 0, rstA = 1, rstB = 1;
  logic [8:0] cfgOffA = 9'd4, cfgOffB = 9'd0;
  logic csNA = 1, wrSelA = 0, wenA = 0, renA = 0;
  logic csNB = 1, wrSelB = 0, wenB = 0, renB = 0;
  logic [17:0] dinA = '0, dinB = '0;
  logic [17:0] doutA, doutB;
  logic doutOeA, inReadyA, outReadyA, halfFullA, almostA;
  logic doutOeB, inReadyB, outReadyB, halfFullB, almostB;
  int checks = 0, failures = 0;

  always #2.5 clkA = ~clkA;  // 200 MHz
  always #3.5 clkB = ~clkB;

  bdfPair dut_i (.*);

  // {csN, wrSel, wen, ren, expOe, expWr}
  localparam logic [5:0] VEC [8] = '{6'b011001, 6'b111000, 6'b010000, 6'b001110,
                                     6'b101100, 6'b011101, 6'b000010, 6'b011001};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeA(logic [17:0] d);
    @(negedge clkA); csNA = 0; wrSelA = 1; wenA = 1; dinA = d;
    @(posedge clkA); #1; wenA = 0; csNA = 1;
  endtask

  task automatic writeB(logic [17:0] d);
    @(negedge clkB); csNB = 0; wrSelB = 1; wenB = 1; dinB = d;
    @(posedge clkB); #1; wenB = 0; csNB = 1;
  endtask

  task automatic readA(output logic [17:0] d, output bit got);
    got = 0; d = '0;
    @(negedge clkA); csNA = 0; wrSelA = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clkA);
      if (outReadyA) begin got = 1; break; end
    end
    if (got) begin d = doutA; renA = 1; @(posedge clkA); #1; renA = 0; end
    csNA = 1;
  endtask

  task automatic readB(output logic [17:0] d, output bit got);
    got = 0; d = '0;
    @(negedge clkB); csNB = 0; wrSelB = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clkB);
      if (outReadyB) begin got = 1; break; end
    end
    if (got) begin d = doutB; renB = 1; @(posedge clkB); #1; renB = 0; end
    csNB = 1;
  endtask

  initial begin
    #900000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [17:0] expQ[$];
    logic [17:0] d;
    bit got;

    // reset both ports, offset 4 for A->B, default for B->A
    repeat (8) @(negedge clkB);
    rstA = 0; rstB = 0;
    repeat (12) @(negedge clkB);
    chk("R9 reset inReadyA", inReadyA, 1);
    chk("R9 reset inReadyB", inReadyB, 1);
    chk("R4 reset outReadyA", outReadyA, 0);
    chk("R4 reset outReadyB", outReadyB, 0);
    chk("R6 reset halfFullA", halfFullA, 0);
    chk("R7 reset almostA", almostA, 1);
    chk("R3 reset doutOeA", doutOeA, 0);
    chk("R3 reset doutA zero", doutA, 0);

    // gating table walked at port A
    for (int i = 0; i < 8; i++) begin
      @(negedge clkA);
      csNA = VEC[i][5]; wrSelA = VEC[i][4]; wenA = VEC[i][3]; renA = VEC[i][2];
      dinA = 18'h100 + 18'(i);
      #1;
      chk($sformatf("R3 oe entry %0d", i), doutOeA, VEC[i][1]);
      if (!VEC[i][1]) chk($sformatf("R3 dout zero entry %0d", i), doutA, 0);
      if (VEC[i][0]) expQ.push_back(18'h100 + 18'(i));
      @(posedge clkA); #1;
      csNA = 1; wenA = 0; renA = 0;
    end
    chk("R11 empty read left outReadyA low", outReadyA, 0);
    foreach (expQ[j]) begin
      readB(d, got);
      chk("R4 word arrives at B", got, 1);
      chk("R1 gated word order", d, expQ[j]);
    end
    repeat (12) @(negedge clkB);
    chk("R1 no extra word stored", outReadyB, 0);

    // reverse direction, B -> A
    for (int i = 0; i < 4; i++) writeB(18'h2A0 + 18'(i));
    for (int i = 0; i < 4; i++) begin
      readA(d, got);
      chk("R10 B->A word", d, 18'h2A0 + 18'(i));
    end
    repeat (12) @(negedge clkA);
    chk("R11 B->A buffer empty after drain", outReadyA, 0);

    // fill A->B to full, checking thresholds (offset 4)
    for (int n = 1; n <= 512; n++) begin
      writeA(18'(n) ^ 18'h15A5);
      if (n == 4)   chk("R7 almost at offset", almostA, 1);
      if (n == 5)   chk("R7 almost above offset", almostA, 0);
      if (n == 256) chk("R6 halfFull at 256", halfFullA, 0);
      if (n == 257) chk("R6 halfFull at 257", halfFullA, 1);
      if (n == 507) chk("R7 almost at 507", almostA, 0);
      if (n == 508) chk("R7 almost at 508", almostA, 1);
      if (n == 511) chk("R5 inReady at 511", inReadyA, 1);
      if (n == 512) chk("R5 inReady at 512", inReadyA, 0);
    end
    writeA(18'h3FFFF);  // dropped, buffer full
    for (int n = 1; n <= 512; n++) begin
      readB(d, got);
      chk("R2 drain order", d, 18'(n) ^ 18'h15A5);
    end
    repeat (12) @(negedge clkB);
    chk("R5 write while full dropped", outReadyB, 0);
    repeat (12) @(negedge clkA);
    chk("R5 inReady back after drain", inReadyA, 1);
    chk("R6 halfFull clear after drain", halfFullA, 0);

    // single-port reset with words parked on both sides, offset 0 -> default
    writeA(18'h111); writeA(18'h112);
    writeB(18'h221); writeB(18'h222);
    repeat (20) @(negedge clkB);
    chk("R4 parked word at B", outReadyB, 1);
    cfgOffA = 9'd0;
    @(negedge clkA); rstA = 1;
    repeat (6) @(negedge clkB);
    @(negedge clkA); rstA = 0;
    repeat (20) @(negedge clkB);
    chk("R9 outReadyB cleared", outReadyB, 0);
    chk("R9 outReadyA cleared", outReadyA, 0);
    chk("R9 inReadyA after reset", inReadyA, 1);
    chk("R9 inReadyB after reset", inReadyB, 1);
    chk("R8 almostA empty", almostA, 1);
    for (int n = 1; n <= 9; n++) begin
      writeA(18'h3000 + 18'(n));
      if (n == 8) chk("R8 default offset at 8", almostA, 1);
      if (n == 9) chk("R8 default offset at 9", almostA, 0);
    end
    readB(d, got);
    chk("R9 first word after reset", d, 18'h3001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule